// File: doc/BRIEF.md
# Data Watchpoint Match Unit

This block watches the data side of a processor for one programmed condition. It holds two software-visible words: a control word and a word-aligned address value. Every cycle it compares the access on a simple access bus against them. The bus carries the address, per-byte enables, direction, privilege, security, swap and exclusive indications, and the outcome of a store-exclusive. When every qualifier agrees, the unit emits a one-cycle debug-event pulse on the next clock.

The address can be matched in two ways. The first is a range formed by dropping low-order address bits. The second is a doubleword or word compared together with a per-byte lane selection. On top of the address, the access is qualified by its type, its privilege and its security state. It can also be tied to an externally computed context-ID match line, chosen by an index held in the control word.

Top module: `wp_match_unit`

## Requirements
- R1: After synchronous reset, both readback ports are zero and `dbg_event` is low; bit 0 of the control word (enable) is therefore clear.
- R2: Control-word bits [31:29], [23:21] and [13] always read zero whatever is written; address-value bits [1:0] always read zero.
- R3: `dbg_event` is high in the cycle after an `acc_valid` cycle whose access matches every qualifier, and low after any cycle without such an access; it never rises while enable (bit 0) is clear.
- R4: Mask field [28:24] = m with m >= 3 compares only address bits [31:m]; m = 0, 1 or 2 applies no mask.
- R5: Unmasked, a hit needs `acc_addr[31:3]` equal to the value's bits [31:3] and an enabled lane that is selected. `acc_be[i]` is the byte at doubleword offset i. If value bit 2 is 1, select bits [8:5] choose lanes 4..7. If value bit 2 is 0, select bit [5+i] chooses lane i. A zero select field never hits.
- R6: With a mask in force, the byte-select field is ignored; any access with at least one byte enabled inside the range hits.
- R7: Type field [4:3]: 01 loads, 10 stores, 11 both, 00 nothing (`acc_write` = 1 is a store).
- R8: A swap matches under type 01, 10 or 11. A load-exclusive matches like a load. A store-exclusive matches under 10 or 11 only with `acc_excl_pass` high.
- R9: Privilege field [2:1]: 01 privileged accesses only, 10 unprivileged only, 11 all, 00 none; `acc_priv` = 1 marks a privileged access.
- R10: Security field [15:14]: 00 both states, 01 non-secure only, 10 secure only, 11 none; `acc_secure` = 1 marks a secure access.
- R11: With link bit [20] set, a hit also needs `ctx_match[k]` high, where k is field [19:16].
- R12: An access in the same cycle as a control-word write is judged against the control word held before that write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_wr_ctrl | input | 1 | Write `cfg_wdata` into the control word |
| cfg_wr_addr | input | 1 | Write `cfg_wdata` into the address value |
| cfg_wdata | input | 32 | Configuration write data |
| ctrl_rdata | output | 32 | Control word readback |
| addr_rdata | output | 32 | Address value readback |
| acc_valid | input | 1 | An access is present this cycle |
| acc_addr | input | 32 | Access byte address |
| acc_be | input | 8 | Byte enables within the aligned doubleword |
| acc_write | input | 1 | 1 = store, 0 = load |
| acc_priv | input | 1 | 1 = privileged access |
| acc_secure | input | 1 | 1 = secure access |
| acc_swap | input | 1 | Access is part of a swap |
| acc_excl | input | 1 | Access is exclusive |
| acc_excl_pass | input | 1 | Store-exclusive passed its monitor |
| ctx_match | input | CTX_N | External context-ID match lines |
| dbg_event | output | 1 | Registered debug-event pulse |

## Verification
A configuration write and an access can land in the same cycle. The register update and the hit decision then race for the same clock edge. The bench provokes this by raising `cfg_wr_ctrl` with a value that disables the watchpoint while it presents an access that hits under the old value. It expects a pulse for that access and none for an identical access one cycle later. The random phase also interleaves control rewrites with accesses, and always predicts from the word held before each write.

// File: rtl/wpm_pkg.sv
package wpm_pkg;

    localparam int WORD_W   = 32;
    localparam int LANES    = 8;
    localparam int MASK_W   = 5;
    localparam int IDX_W    = 4;
    localparam int MIN_MASK = 3;

    localparam logic [WORD_W-1:0] CTRL_WMASK = 32'h1F1F_DFFF;
    localparam logic [WORD_W-1:0] ADDR_WMASK = 32'hFFFF_FFFC;

    typedef struct packed {
        logic [2:0]        rsv_hi;
        logic [MASK_W-1:0] mask;
        logic [2:0]        rsv_mid;
        logic              link_en;
        logic [IDX_W-1:0]  link_idx;
        logic [1:0]        sec;
        logic              rsv_lo;
        logic [LANES-1:0]  bsel;
        logic [1:0]        ls;
        logic [1:0]        priv;
        logic              en;
    } wp_ctrl_t;

    typedef struct packed {
        logic [WORD_W-1:0] addr;
        logic [LANES-1:0]  be;
        logic              write;
        logic              priv;
        logic              secure;
        logic              swap;
        logic              excl;
        logic              excl_pass;
    } wp_acc_t;

    typedef enum logic [1:0] {
        SEC_BOTH = 2'b00,
        SEC_NS   = 2'b01,
        SEC_S    = 2'b10,
        SEC_RSVD = 2'b11
    } sec_sel_e;

    function automatic logic [MASK_W-1:0] eff_mask(input logic [MASK_W-1:0] m);
        if (m < MASK_W'(MIN_MASK)) return '0;
        return m;
    endfunction

    function automatic logic [LANES-1:0] lane_map(input logic [LANES-1:0] bsel,
                                                 input logic upper_word);
        if (upper_word) return {bsel[LANES/2-1:0], {(LANES/2){1'b0}}};
        return bsel;
    endfunction

    function automatic logic type_ok(input logic [1:0] ls, input logic write,
                                     input logic swap, input logic excl,
                                     input logic excl_pass);
        logic want_ld;
        logic want_st;
        want_ld = ls[0];
        want_st = ls[1];
        if (swap) return want_ld | want_st;
        if (excl && write) return want_st & excl_pass;
        if (write) return want_st;
        return want_ld;
    endfunction

    function automatic logic priv_ok(input logic [1:0] sel, input logic priv);
        return priv ? sel[0] : sel[1];
    endfunction

    function automatic logic sec_ok(input logic [1:0] sel, input logic secure);
        case (sec_sel_e'(sel))
            SEC_BOTH: return 1'b1;
            SEC_NS:   return ~secure;
            SEC_S:    return secure;
            default:  return 1'b0;
        endcase
    endfunction

endpackage

// File: rtl/wpm_regs.sv
module wpm_regs
    import wpm_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_ctrl,
    input  logic              wr_addr,
    input  logic [WORD_W-1:0] wdata,
    output wp_ctrl_t          ctrl_q,
    output logic [WORD_W-1:0] addr_q
);

    always_ff @(posedge clk) begin
        if (rst) begin
            ctrl_q <= '0;
            addr_q <= '0;
        end else begin
            if (wr_ctrl) ctrl_q <= wp_ctrl_t'(wdata & CTRL_WMASK);
            if (wr_addr) addr_q <= wdata & ADDR_WMASK;
        end
    end

    a_r2_ctrl_rsvd_zero: assert property (@(posedge clk) disable iff (rst)
        (ctrl_q.rsv_hi == '0) && (ctrl_q.rsv_mid == '0) && (ctrl_q.rsv_lo == 1'b0));

    a_r2_addr_aligned: assert property (@(posedge clk) disable iff (rst)
        addr_q[1:0] == 2'b00);

    a_r12_ctrl_hold: assert property (@(posedge clk) disable iff (rst)
        !wr_ctrl |=> $stable(ctrl_q));

endmodule

// File: rtl/wpm_addr_cmp.sv
module wpm_addr_cmp
    import wpm_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic [MASK_W-1:0] mask,
    input  logic [LANES-1:0]  bsel,
    input  logic [WORD_W-1:0] wv,
    input  logic [WORD_W-1:0] acc_addr,
    input  logic [LANES-1:0]  acc_be,
    output logic              addr_hit
);

    localparam int LANE_SH = $clog2(LANES);

    logic [MASK_W-1:0] m_eff;
    logic [WORD_W-1:0] keep;
    logic [LANES-1:0]  lane_sel;
    logic [LANES-1:0]  lane_hit;
    logic              range_eq;
    logic              dword_eq;

    always_comb begin
        m_eff    = eff_mask(mask);
        keep     = ~((WORD_W'(1) << m_eff) - WORD_W'(1));
        range_eq = ((acc_addr ^ wv) & keep) == '0;
        dword_eq = acc_addr[WORD_W-1:LANE_SH] == wv[WORD_W-1:LANE_SH];
        lane_sel = lane_map(bsel, wv[LANE_SH-1]);
    end

    for (genvar i = 0; i < LANES; i++) begin : g_lane
        assign lane_hit[i] = acc_be[i] & lane_sel[i];
    end

    assign addr_hit = (m_eff != '0) ? (range_eq & (|acc_be))
                                    : (dword_eq & (|lane_hit));

    a_r5_zero_select: assert property (@(posedge clk) disable iff (rst)
        (m_eff == '0 && bsel == '0) |-> !addr_hit);

    a_r6_no_bytes: assert property (@(posedge clk) disable iff (rst)
        (acc_be == '0) |-> !addr_hit);

    a_r4_outside_range: assert property (@(posedge clk) disable iff (rst)
        (m_eff != '0 && ((acc_addr ^ wv) >> m_eff) != '0) |-> !addr_hit);

endmodule

// File: rtl/wpm_qual.sv
module wpm_qual
    import wpm_pkg::*;
#(
    parameter int CTX_N = 16
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [1:0]       ls,
    input  logic [1:0]       priv_sel,
    input  logic [1:0]       sec_sel,
    input  logic             link_en,
    input  logic [IDX_W-1:0] link_idx,
    input  logic             acc_write,
    input  logic             acc_priv,
    input  logic             acc_secure,
    input  logic             acc_swap,
    input  logic             acc_excl,
    input  logic             acc_excl_pass,
    input  logic [CTX_N-1:0] ctx_match,
    output logic             qual_ok
);

    localparam int SPAN = 1 << IDX_W;

    logic [SPAN-1:0] ctx_ext;

    if (CTX_N >= SPAN) begin : g_ctx_full
        assign ctx_ext = ctx_match[SPAN-1:0];
    end else begin : g_ctx_pad
        assign ctx_ext = {{(SPAN-CTX_N){1'b0}}, ctx_match};
    end

    logic t_ok, p_ok, s_ok, l_ok;

    always_comb begin
        t_ok    = type_ok(ls, acc_write, acc_swap, acc_excl, acc_excl_pass);
        p_ok    = priv_ok(priv_sel, acc_priv);
        s_ok    = sec_ok(sec_sel, acc_secure);
        l_ok    = ~link_en | ctx_ext[link_idx];
        qual_ok = t_ok & p_ok & s_ok & l_ok;
    end

    a_r7_type_reserved: assert property (@(posedge clk) disable iff (rst)
        (ls == 2'b00) |-> !qual_ok);

    a_r8_failed_strex: assert property (@(posedge clk) disable iff (rst)
        (acc_excl && acc_write && !acc_swap && !acc_excl_pass) |-> !qual_ok);

    a_r9_priv_reserved: assert property (@(posedge clk) disable iff (rst)
        (priv_sel == 2'b00) |-> !qual_ok);

    a_r10_sec_reserved: assert property (@(posedge clk) disable iff (rst)
        (sec_sel == 2'b11) |-> !qual_ok);

    a_r11_link_miss: assert property (@(posedge clk) disable iff (rst)
        (link_en && !ctx_ext[link_idx]) |-> !qual_ok);

endmodule

// File: rtl/wp_match_unit.sv
module wp_match_unit
    import wpm_pkg::*;
#(
    parameter int CTX_N = 16
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              cfg_wr_ctrl,
    input  logic              cfg_wr_addr,
    input  logic [WORD_W-1:0] cfg_wdata,
    output logic [WORD_W-1:0] ctrl_rdata,
    output logic [WORD_W-1:0] addr_rdata,
    input  logic              acc_valid,
    input  logic [WORD_W-1:0] acc_addr,
    input  logic [LANES-1:0]  acc_be,
    input  logic              acc_write,
    input  logic              acc_priv,
    input  logic              acc_secure,
    input  logic              acc_swap,
    input  logic              acc_excl,
    input  logic              acc_excl_pass,
    input  logic [CTX_N-1:0]  ctx_match,
    output logic              dbg_event
);

    wp_ctrl_t          ctrl_q;
    logic [WORD_W-1:0] addr_q;
    wp_acc_t           acc;
    logic              addr_hit;
    logic              qual_ok;
    logic              hit_now;

    assign acc = '{addr: acc_addr, be: acc_be, write: acc_write, priv: acc_priv,
                   secure: acc_secure, swap: acc_swap, excl: acc_excl,
                   excl_pass: acc_excl_pass};

    wpm_regs u_regs (
        .clk     (clk),
        .rst     (rst),
        .wr_ctrl (cfg_wr_ctrl),
        .wr_addr (cfg_wr_addr),
        .wdata   (cfg_wdata),
        .ctrl_q  (ctrl_q),
        .addr_q  (addr_q)
    );

    wpm_addr_cmp u_addr (
        .clk      (clk),
        .rst      (rst),
        .mask     (ctrl_q.mask),
        .bsel     (ctrl_q.bsel),
        .wv       (addr_q),
        .acc_addr (acc.addr),
        .acc_be   (acc.be),
        .addr_hit (addr_hit)
    );

    wpm_qual #(.CTX_N(CTX_N)) u_qual (
        .clk           (clk),
        .rst           (rst),
        .ls            (ctrl_q.ls),
        .priv_sel      (ctrl_q.priv),
        .sec_sel       (ctrl_q.sec),
        .link_en       (ctrl_q.link_en),
        .link_idx      (ctrl_q.link_idx),
        .acc_write     (acc.write),
        .acc_priv      (acc.priv),
        .acc_secure    (acc.secure),
        .acc_swap      (acc.swap),
        .acc_excl      (acc.excl),
        .acc_excl_pass (acc.excl_pass),
        .ctx_match     (ctx_match),
        .qual_ok       (qual_ok)
    );

    assign hit_now    = acc_valid & ctrl_q.en & addr_hit & qual_ok;
    assign ctrl_rdata = ctrl_q;
    assign addr_rdata = addr_q;

    always_ff @(posedge clk) begin
        if (rst) dbg_event <= 1'b0;
        else     dbg_event <= hit_now;
    end

    a_r3_needs_access: assert property (@(posedge clk) disable iff (rst)
        dbg_event |-> $past(acc_valid));

    a_r3_disabled_quiet: assert property (@(posedge clk) disable iff (rst)
        !ctrl_q.en |=> !dbg_event);

endmodule

// File: tb/wp_match_unit_bench.sv
`timescale 1ns/1ps
module wp_match_unit_bench;

    logic        clk = 1'b0;
    logic        rst;
    logic        cfg_wr_ctrl, cfg_wr_addr;
    logic [31:0] cfg_wdata;
    logic [31:0] ctrl_rdata, addr_rdata;
    logic        acc_valid;
    logic [31:0] acc_addr;
    logic [7:0]  acc_be;
    logic        acc_write, acc_priv, acc_secure, acc_swap, acc_excl, acc_excl_pass;
    logic [15:0] ctx_match;
    logic        dbg_event;

    int tests = 0;
    int fails = 0;
    logic [31:0] m_ctrl = 32'h0;
    logic [31:0] m_addr = 32'h0;

    always #2.5 clk = ~clk;

    wp_match_unit u_wp_match_unit (
        .clk(clk), .rst(rst), .cfg_wr_ctrl(cfg_wr_ctrl), .cfg_wr_addr(cfg_wr_addr),
        .cfg_wdata(cfg_wdata), .ctrl_rdata(ctrl_rdata), .addr_rdata(addr_rdata),
        .acc_valid(acc_valid), .acc_addr(acc_addr), .acc_be(acc_be),
        .acc_write(acc_write), .acc_priv(acc_priv), .acc_secure(acc_secure),
        .acc_swap(acc_swap), .acc_excl(acc_excl), .acc_excl_pass(acc_excl_pass),
        .ctx_match(ctx_match), .dbg_event(dbg_event)
    );

    function automatic logic [31:0] mk(input bit en, input bit [1:0] ls, input bit [1:0] pv,
                                       input bit [1:0] sc, input bit [7:0] bs,
                                       input bit [4:0] mk_m, input bit le, input bit [3:0] ix);
        return {3'b0, mk_m, 3'b0, le, ix, sc, 1'b0, bs, ls, pv, en};
    endfunction

    function automatic bit predict(input logic [31:0] c, input logic [31:0] wv,
                                   input logic [31:0] a, input logic [7:0] be,
                                   input bit wr, input bit pv, input bit sc, input bit sw,
                                   input bit ex, input bit ep, input logic [15:0] cx);
        int m;
        bit ok;
        logic [7:0] lanes;
        logic [1:0] ls, pf, sf;
        if (!c[0]) return 0;
        m = int'(c[28:24]);
        if (m < 3) m = 0;
        if (m == 0) begin
            lanes = wv[2] ? {c[8:5], 4'b0} : c[12:5];
            ok = (a[31:3] == wv[31:3]) && ((be & lanes) != 0);
        end else begin
            ok = (((a ^ wv) >> m) == 0) && (be != 0);
        end
        ls = c[4:3];
        if (sw)            ok &= (ls != 0);
        else if (ex && wr) ok &= ls[1] && ep;
        else if (wr)       ok &= ls[1];
        else               ok &= ls[0];
        pf = c[2:1];
        ok &= pv ? pf[0] : pf[1];
        sf = c[15:14];
        ok &= (sf == 0) || (sf == 1 && !sc) || (sf == 2 && sc);
        if (c[20]) ok &= cx[c[19:16]];
        return ok;
    endfunction

    task automatic chk(input logic [31:0] got, input logic [31:0] exp, input string tag);
        tests++;
        if (got !== exp) begin
            fails++;
            $display("FAIL %s: got %h expected %h", tag, got, exp);
        end
    endtask

    task automatic wr_ctrl(input logic [31:0] v);
        @(negedge clk);
        cfg_wr_ctrl = 1; cfg_wdata = v;
        @(negedge clk);
        cfg_wr_ctrl = 0;
        m_ctrl = v & 32'h1F1F_DFFF;
    endtask

    task automatic wr_addr(input logic [31:0] v);
        @(negedge clk);
        cfg_wr_addr = 1; cfg_wdata = v;
        @(negedge clk);
        cfg_wr_addr = 0;
        m_addr = v & 32'hFFFF_FFFC;
    endtask

    task automatic drive(input logic [31:0] a, input logic [7:0] be, input bit wr,
                         input bit pv, input bit sc, input bit sw, input bit ex,
                         input bit ep, input logic [15:0] cx);
        acc_valid = 1; acc_addr = a; acc_be = be; acc_write = wr; acc_priv = pv;
        acc_secure = sc; acc_swap = sw; acc_excl = ex; acc_excl_pass = ep; ctx_match = cx;
    endtask

    task automatic access(input logic [31:0] a, input logic [7:0] be, input bit wr,
                          input bit pv, input bit sc, input bit sw, input bit ex,
                          input bit ep, input logic [15:0] cx, input string tag);
        bit exp;
        @(negedge clk);
        drive(a, be, wr, pv, sc, sw, ex, ep, cx);
        exp = predict(m_ctrl, m_addr, a, be, wr, pv, sc, sw, ex, ep, cx);
        @(negedge clk);
        acc_valid = 0;
        chk({31'b0, dbg_event}, {31'b0, exp}, tag);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        fails++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        logic [31:0] allon;
        void'($urandom(32'd20240611));
        rst = 1; cfg_wr_ctrl = 0; cfg_wr_addr = 0; cfg_wdata = 0;
        acc_valid = 0; acc_addr = 0; acc_be = 0; acc_write = 0; acc_priv = 0;
        acc_secure = 0; acc_swap = 0; acc_excl = 0; acc_excl_pass = 0; ctx_match = 0;
        repeat (3) @(negedge clk);
        rst = 0;
        @(negedge clk);
        // R1 reset state
        chk(ctrl_rdata, 32'h0, "R1 ctrl reset");
        chk(addr_rdata, 32'h0, "R1 addr reset");
        chk({31'b0, dbg_event}, 32'h0, "R1 event reset");

        // R2 reserved bits
        wr_ctrl(32'hFFFF_FFFE);
        chk(ctrl_rdata, 32'h1F1F_DFFE, "R2 ctrl reserved zero");
        wr_addr(32'hFFFF_FFFF);
        chk(addr_rdata, 32'hFFFF_FFFC, "R2 addr low bits zero");

        allon = mk(1, 2'b11, 2'b11, 2'b00, 8'h01, 5'd0, 0, 4'd0);
        // R3 basic hit and single pulse
        wr_addr(32'h0000_1000);
        wr_ctrl(allon);
        access(32'h1000, 8'h01, 0, 1, 0, 0, 0, 0, 16'h0, "R3 basic hit");
        chk({31'b0, dbg_event}, 32'h1, "R3 hit pulse high");
        @(negedge clk);
        chk({31'b0, dbg_event}, 32'h0, "R3 pulse ends");
        // R5 lanes
        access(32'h1000, 8'h02, 0, 1, 0, 0, 0, 0, 16'h0, "R5 unselected lane");
        access(32'h1008, 8'h01, 0, 1, 0, 0, 0, 0, 16'h0, "R5 other doubleword");
        wr_addr(32'h0000_1004);
        access(32'h1004, 8'h10, 0, 1, 0, 0, 0, 0, 16'h0, "R5 upper word lane4");
        access(32'h1000, 8'h01, 0, 1, 0, 0, 0, 0, 16'h0, "R5 upper word lane0 miss");
        wr_ctrl(mk(1, 2'b11, 2'b11, 2'b00, 8'h00, 5'd0, 0, 4'd0));
        access(32'h1004, 8'hFF, 0, 1, 0, 0, 0, 0, 16'h0, "R5 zero select");
        // R4 / R6 mask
        wr_addr(32'h0000_1000);
        wr_ctrl(mk(1, 2'b11, 2'b11, 2'b00, 8'h01, 5'd2, 0, 4'd0));
        access(32'h1008, 8'h01, 0, 1, 0, 0, 0, 0, 16'h0, "R4 reserved mask no range");
        wr_ctrl(mk(1, 2'b11, 2'b11, 2'b00, 8'h00, 5'd5, 0, 4'd0));
        access(32'h101C, 8'h80, 0, 1, 0, 0, 0, 0, 16'h0, "R6 mask ignores select");
        access(32'h1020, 8'h01, 0, 1, 0, 0, 0, 0, 16'h0, "R4 outside mask range");
        // R7 type
        wr_ctrl(mk(1, 2'b00, 2'b11, 2'b00, 8'hFF, 5'd0, 0, 4'd0));
        access(32'h1000, 8'h01, 0, 1, 0, 0, 0, 0, 16'h0, "R7 reserved type");
        wr_ctrl(mk(1, 2'b01, 2'b11, 2'b00, 8'hFF, 5'd0, 0, 4'd0));
        access(32'h1000, 8'h01, 1, 1, 0, 0, 0, 0, 16'h0, "R7 store under load-only");
        access(32'h1000, 8'h01, 0, 1, 0, 0, 0, 0, 16'h0, "R7 load under load-only");
        // R8 swap / exclusive
        access(32'h1000, 8'h01, 1, 1, 0, 1, 0, 0, 16'h0, "R8 swap store under 01");
        access(32'h1000, 8'h01, 0, 1, 0, 0, 1, 0, 16'h0, "R8 load-exclusive under 01");
        wr_ctrl(mk(1, 2'b11, 2'b11, 2'b00, 8'hFF, 5'd0, 0, 4'd0));
        access(32'h1000, 8'h01, 1, 1, 0, 0, 1, 0, 16'h0, "R8 failed store-exclusive");
        access(32'h1000, 8'h01, 1, 1, 0, 0, 1, 1, 16'h0, "R8 passed store-exclusive");
        // R9 privilege
        wr_ctrl(mk(1, 2'b11, 2'b01, 2'b00, 8'hFF, 5'd0, 0, 4'd0));
        access(32'h1000, 8'h01, 0, 0, 0, 0, 0, 0, 16'h0, "R9 user under priv-only");
        wr_ctrl(mk(1, 2'b11, 2'b00, 2'b00, 8'hFF, 5'd0, 0, 4'd0));
        access(32'h1000, 8'h01, 0, 1, 0, 0, 0, 0, 16'h0, "R9 reserved privilege");
        // R10 security
        wr_ctrl(mk(1, 2'b11, 2'b11, 2'b11, 8'hFF, 5'd0, 0, 4'd0));
        access(32'h1000, 8'h01, 0, 1, 1, 0, 0, 0, 16'h0, "R10 reserved security");
        wr_ctrl(mk(1, 2'b11, 2'b11, 2'b10, 8'hFF, 5'd0, 0, 4'd0));
        access(32'h1000, 8'h01, 0, 1, 0, 0, 0, 0, 16'h0, "R10 nonsecure under secure-only");
        access(32'h1000, 8'h01, 0, 1, 1, 0, 0, 0, 16'h0, "R10 secure under secure-only");
        // R11 link
        wr_ctrl(mk(1, 2'b11, 2'b11, 2'b00, 8'hFF, 5'd0, 1, 4'd5));
        access(32'h1000, 8'h01, 0, 1, 0, 0, 0, 0, 16'hFFDF, "R11 linked line low");
        access(32'h1000, 8'h01, 0, 1, 0, 0, 0, 0, 16'h0020, "R11 linked line high");
        // R3 disabled
        wr_ctrl(mk(0, 2'b11, 2'b11, 2'b00, 8'hFF, 5'd0, 0, 4'd0));
        access(32'h1000, 8'hFF, 0, 1, 0, 0, 0, 0, 16'h0, "R3 disabled");
        // R12 same-cycle write and access
        wr_ctrl(mk(1, 2'b11, 2'b11, 2'b00, 8'hFF, 5'd0, 0, 4'd0));
        @(negedge clk);
        drive(32'h1000, 8'h01, 0, 1, 0, 0, 0, 0, 16'h0);
        cfg_wr_ctrl = 1; cfg_wdata = 32'h0;
        @(negedge clk);
        cfg_wr_ctrl = 0; m_ctrl = 32'h0;
        chk({31'b0, dbg_event}, 32'h1, "R12 access uses old control");
        @(negedge clk);
        acc_valid = 0;
        chk({31'b0, dbg_event}, 32'h0, "R12 next access uses new control");

        // Random phase, all requirements
        for (int k = 0; k < 30; k++) begin
            logic [31:0] c;
            c = $urandom;
            c[0] = ($urandom % 8) != 0;
            if ($urandom % 2) begin c[4:3] = 2'b11; c[2:1] = 2'b11; c[15:14] = 2'b00; end
            if ($urandom % 3) c[20] = 1'b0;
            if ($urandom % 2) c[28:24] = 5'($urandom % 3);
            wr_addr($urandom);
            if ($urandom % 2) wr_ctrl(c);
            else begin
                // R12 random overlap of control write and access
                @(negedge clk);
                drive(m_addr, 8'hFF, 0, 1, 0, 0, 0, 0, 16'hFFFF);
                cfg_wr_ctrl = 1; cfg_wdata = c;
                begin
                    bit e;
                    e = predict(m_ctrl, m_addr, m_addr, 8'hFF, 0, 1, 0, 0, 0, 0, 16'hFFFF);
                    @(negedge clk);
                    cfg_wr_ctrl = 0; acc_valid = 0; m_ctrl = c & 32'h1F1F_DFFF;
                    chk({31'b0, dbg_event}, {31'b0, e}, "R12 random overlap");
                end
            end
            for (int j = 0; j < 40; j++) begin
                logic [31:0] near;
                int kind;
                case ($urandom % 4)
                    0: near = 32'h7;
                    1: near = 32'hF;
                    2: near = 32'hFF;
                    default: near = 32'hFFFF;
                endcase
                kind = $urandom % 4;
                access(m_addr ^ ($urandom & near), 8'($urandom), 1'($urandom),
                       1'($urandom), 1'($urandom), kind == 1, kind == 2,
                       1'($urandom), 16'($urandom), "R3 R4 R5 R6 R7 R8 R9 R10 R11 random");
            end
        end

        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

endmodule